// File: doc/BRIEF.md
# Byte-Loaded Sequential RAM Address Generator

This block lets a host with a narrow 8-bit port reach a 64K x 8 RAM. Inside it sits a 16-bit address built from byte-wide stages. While the load/count select is low, each address step shifts a byte from the host bus into the lowest stage. Every other stage takes over the byte held below it. Two steps therefore place a full address: the high byte goes first and the low byte second. While the select is high, the same stages form a single counter, and each step adds one with carry across stage boundaries.

The block also drives the RAM strobes and decides which side drives the shared bus. A parameter selects one of two strobe schemes:
- **Separate-strobe scheme:** the host has an active-low read request and an active-low write strobe.
- **Reduced-pin scheme:** one active-low go strobe is decoded by the select. A low select makes go a write. A high select makes go a read.

The address only moves while no write strobe is active, so a write always lands at a stable address.

Top module: `seq_ram_addr_gen`

## Requirements
- R1: An asynchronous active-low reset clears every address stage, giving address 0x0000, with both RAM strobes deasserted.
- R2: A step with select low loads the host bus byte into bits [7:0]. Each higher byte of the address takes the previous value of the byte below it.
- R3: Two load steps carrying H and then L give the address {H, L}.
- R4: A step with select high increments the whole address by one, and carry passes from bits [7:0] into bits [15:8].
- R5: Incrementing 0xFFFF gives 0x0000.
- R6: With select low, the RAM output enable (active low) stays high and the host bus drive enable stays high, in both schemes.
- R7: Separate-strobe scheme: with select high, a low read request with the write strobe high drives the RAM output enable low and the host drive enable low, and passes the RAM data to the host read data. When no read is active, the host read data is 0x00.
- R8: While the RAM write strobe is low, steps are ignored and the address holds.
- R9: Reduced-pin scheme: go low with select low drives the write strobe low. Go low with select high drives the output enable low. The separate read request and write strobe inputs have no effect.
- R10: The RAM write data always equals the host bus byte.
- R11: The RAM write strobe and the RAM output enable are never low together. In the separate-strobe scheme a write takes precedence over a read request. In that scheme the go input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_sel | input | 1 | 0 = load, 1 = count |
| step | input | 1 | One-cycle address clock enable |
| host_wdata | input | 8 | Byte the host drives onto the bus |
| rd_req_n | input | 1 | Read request, active low (separate-strobe scheme) |
| wr_n | input | 1 | Write strobe, active low (separate-strobe scheme) |
| go_n | input | 1 | Combined strobe, active low (reduced-pin scheme) |
| ram_rdata | input | 8 | Byte driven by the RAM |
| ram_addr | output | 16 | Current RAM address |
| ram_wdata | output | 8 | Byte presented to the RAM for writes |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| host_bus_oe | output | 1 | High when the host owns the bus |
| host_rdata | output | 8 | RAM byte returned to the host |

## Verification
The bench builds two copies of the block, both with two byte stages. One copy uses the separate-strobe scheme and the other uses the reduced-pin scheme. Both copies receive the same stimulus, so each one shows how it treats the strobes that belong to the other scheme. In each scheme a block of bytes is written from start address 0x12FC, crossing the carry into the high byte. The start address is then reloaded and the bytes are read back in order.

// File: rtl/seq_ram_addr_gen.sv
module seq_ram_addr_gen #(
  parameter int STAGES      = 2,
  parameter int BYTE_W      = 8,
  parameter bit REDUCED_PIN = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cnt_sel,
  input  logic                       step,
  input  logic [BYTE_W-1:0]          host_wdata,
  input  logic                       rd_req_n,
  input  logic                       wr_n,
  input  logic                       go_n,
  input  logic [BYTE_W-1:0]          ram_rdata,
  output logic [STAGES*BYTE_W-1:0]   ram_addr,
  output logic [BYTE_W-1:0]          ram_wdata,
  output logic                       ram_we_n,
  output logic                       ram_oe_n,
  output logic                       host_bus_oe,
  output logic [BYTE_W-1:0]          host_rdata
);
  localparam int ADDR_W = STAGES * BYTE_W;

  logic [BYTE_W-1:0] stg [STAGES];
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic              write_act, read_act, adv;

  generate
    if (REDUCED_PIN) begin : g_rp
      logic unused_sep;
      assign unused_sep = rd_req_n ^ wr_n;
      assign write_act  = !go_n && !cnt_sel;
      assign read_act   = !go_n &&  cnt_sel;
    end else begin : g_sep
      logic unused_go;
      assign unused_go = go_n;
      assign write_act = !wr_n;
      assign read_act  = !rd_req_n && cnt_sel && wr_n;
    end
  endgenerate

  assign adv      = step && !write_act;
  assign addr_inc = addr_q + 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign addr_q[i*BYTE_W +: BYTE_W] = stg[i];
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)   stg[i] <= '0;
        else if (adv) stg[i] <= cnt_sel ? addr_inc[BYTE_W-1:0] : host_wdata;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)   stg[i] <= '0;
        else if (adv) stg[i] <= cnt_sel ? addr_inc[i*BYTE_W +: BYTE_W] : stg[i-1];
    end
  end

  assign ram_addr    = addr_q;
  assign ram_wdata   = host_wdata;
  assign ram_we_n    = !write_act;
  assign ram_oe_n    = !read_act;
  assign host_bus_oe = !read_act;
  assign host_rdata  = read_act ? ram_rdata : '0;
endmodule

// File: rtl/seq_ram_addr_gen_chk.sv
module seq_ram_addr_gen_chk #(
  parameter int STAGES = 2,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cnt_sel,
  input logic                     step,
  input logic [BYTE_W-1:0]        host_wdata,
  input logic [STAGES*BYTE_W-1:0] ram_addr,
  input logic [BYTE_W-1:0]        ram_wdata,
  input logic                     ram_we_n,
  input logic                     ram_oe_n,
  input logic                     host_bus_oe
);
  localparam int ADDR_W = STAGES * BYTE_W;

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  p_load_no_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_sel |-> (ram_oe_n && host_bus_oe));

  p_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_sel && ram_we_n) |=>
      ram_addr == {$past(ram_addr[ADDR_W-BYTE_W-1:0]), $past(host_wdata)});

  p_count_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_sel && ram_we_n) |=> ram_addr == $past(ram_addr) + 1'b1);

  p_hold_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !step) |=> $stable(ram_addr));

  p_wdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wdata == host_wdata);
endmodule

bind seq_ram_addr_gen seq_ram_addr_gen_chk #(.STAGES(STAGES), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_sel(cnt_sel), .step(step), .host_wdata(host_wdata),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n), .host_bus_oe(host_bus_oe));

// File: tb/seq_ram_addr_gen_tb_top.sv
module seq_ram_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 8;
  localparam logic [15:0] START = 16'h12FC;

  // {select, bus byte, expected address after the step} for the separate-strobe copy
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'h12, 16'h0012},  // R2
    {1'b0, 8'h34, 16'h1234},  // R3
    {1'b1, 8'h00, 16'h1235},  // R4
    {1'b1, 8'h55, 16'h1236},  // R4
    {1'b0, 8'hFF, 16'h36FF},  // R2
    {1'b1, 8'h00, 16'h3700},  // R4 carry
    {1'b0, 8'hAB, 16'h00AB},  // R2
    {1'b0, 8'hFF, 16'hABFF},  // R3
    {1'b1, 8'h00, 16'hAC00},  // R4 carry
    {1'b0, 8'h00, 16'h0000}   // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_sel = 1'b0, step = 1'b0, rd_req_n = 1'b1, wr_n = 1'b1, go_n = 1'b1;
  logic [7:0] bus = 8'h00;
  logic [7:0] a_rdata, b_rdata, a_wdata, b_wdata, a_hrd, b_hrd;
  logic [15:0] a_addr, b_addr;
  logic a_we_n, a_oe_n, a_hoe, b_we_n, b_oe_n, b_hoe;
  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_ram_addr_gen #(.STAGES(2), .BYTE_W(8), .REDUCED_PIN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_sel(cnt_sel), .step(step), .host_wdata(bus),
    .rd_req_n(rd_req_n), .wr_n(wr_n), .go_n(go_n), .ram_rdata(a_rdata),
    .ram_addr(a_addr), .ram_wdata(a_wdata), .ram_we_n(a_we_n), .ram_oe_n(a_oe_n),
    .host_bus_oe(a_hoe), .host_rdata(a_hrd));

  seq_ram_addr_gen #(.STAGES(2), .BYTE_W(8), .REDUCED_PIN(1'b1)) dut_rp_i (
    .clk(clk), .rst_n(rst_n), .cnt_sel(cnt_sel), .step(step), .host_wdata(bus),
    .rd_req_n(rd_req_n), .wr_n(wr_n), .go_n(go_n), .ram_rdata(b_rdata),
    .ram_addr(b_addr), .ram_wdata(b_wdata), .ram_we_n(b_we_n), .ram_oe_n(b_oe_n),
    .host_bus_oe(b_hoe), .host_rdata(b_hrd));

  assign a_rdata = mem_a[a_addr[7:0]];
  assign b_rdata = mem_b[b_addr[7:0]];
  always @(posedge clk) begin
    if (!a_we_n) mem_a[a_addr[7:0]] <= a_wdata;
    if (!b_we_n) mem_b[b_addr[7:0]] <= b_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic sel, input logic [7:0] d);
    cnt_sel = sel; bus = d; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int k, input bit rp);
    return 8'hA5 ^ 8'(k * 13) ^ (rp ? 8'h3C : 8'h00);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 addr", a_addr, 16'h0000);
    chk("R1 rp addr", b_addr, 16'h0000);
    chk("R1 strobes", {a_we_n, a_oe_n, b_we_n, b_oe_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      pulse(VEC[i][24], VEC[i][23:16]);
      chk("R2/R3/R4 table", a_addr, VEC[i][15:0]);
      chk("R2/R3/R4 table rp", b_addr, VEC[i][15:0]);
    end

    // R5: wrap
    pulse(1'b0, 8'hFF); pulse(1'b0, 8'hFF);
    chk("R3 FFFF", a_addr, 16'hFFFF);
    pulse(1'b1, 8'h00);
    chk("R5 wrap", a_addr, 16'h0000);
    chk("R5 wrap rp", b_addr, 16'h0000);

    // R6: load phase keeps RAM off the bus, even with a request
    cnt_sel = 1'b0; rd_req_n = 1'b0; go_n = 1'b1; #1;
    chk("R6 sep", {a_oe_n, a_hoe}, 2'b11);
    chk("R6 rp", {b_oe_n, b_hoe}, 2'b11);
    rd_req_n = 1'b1;

    // R11: write wins over read in the separate scheme; R9: rp ignores wr_n/rd_req_n
    cnt_sel = 1'b1; rd_req_n = 1'b0; wr_n = 1'b0; bus = 8'h5A; #1;
    chk("R11 write wins", {a_we_n, a_oe_n}, 2'b01);
    chk("R9 rp ignores sep strobes", {b_we_n, b_oe_n}, 2'b11);
    chk("R10 wdata", a_wdata, 8'h5A);
    @(negedge clk);
    rd_req_n = 1'b1; wr_n = 1'b1;

    // R11: go ignored in the separate scheme
    cnt_sel = 1'b0; go_n = 1'b0; #1;
    chk("R11 sep ignores go", {a_we_n, a_oe_n}, 2'b11);
    chk("R9 rp write decode", {b_we_n, b_oe_n}, 2'b01);
    cnt_sel = 1'b1; #1;
    chk("R9 rp read decode", {b_we_n, b_oe_n, b_hoe}, 3'b100);
    go_n = 1'b1;
    @(negedge clk);

    // Separate scheme block write from START (crosses carry)
    pulse(1'b0, START[15:8]); pulse(1'b0, START[7:0]);
    chk("R3 start", a_addr, START);
    for (int k = 0; k < NBLK; k++) begin
      cnt_sel = 1'b1; bus = pat(k, 0); wr_n = 1'b0; step = 1'b1;
      @(negedge clk);
      step = 1'b0; wr_n = 1'b1;
      chk("R8 step ignored while writing", a_addr, START + 16'(k));
      pulse(1'b1, 8'h00);
    end
    chk("R4 after block", a_addr, START + 16'(NBLK));
    pulse(1'b0, START[15:8]); pulse(1'b0, START[7:0]);
    cnt_sel = 1'b1; rd_req_n = 1'b0;
    for (int k = 0; k < NBLK; k++) begin
      #1;
      chk("R7 host owns bus off", {a_oe_n, a_hoe}, 2'b00);
      chk("R7 read back", a_hrd, pat(k, 0));
      pulse(1'b1, 8'h00);
    end
    rd_req_n = 1'b1; #1;
    chk("R7 idle rdata", a_hrd, 8'h00);

    // Reduced-pin block write and read back
    @(negedge clk);
    pulse(1'b0, START[15:8]); pulse(1'b0, START[7:0]);
    chk("R3 rp start", b_addr, START);
    for (int k = 0; k < NBLK; k++) begin
      cnt_sel = 1'b0; bus = pat(k, 1); go_n = 1'b0; step = 1'b1;
      @(negedge clk);
      step = 1'b0; go_n = 1'b1;
      chk("R8 rp step ignored while writing", b_addr, START + 16'(k));
      pulse(1'b1, 8'h00);
      cnt_sel = 1'b0;
    end
    pulse(1'b0, START[15:8]); pulse(1'b0, START[7:0]);
    cnt_sel = 1'b1; go_n = 1'b0;
    for (int k = 0; k < NBLK; k++) begin
      #1;
      chk("R9 rp read back", b_hrd, pat(k, 1));
      pulse(1'b1, 8'h00);
    end
    go_n = 1'b1;

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0; #1;
    chk("R1 async clear", {a_addr, b_addr}, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule